// File: doc/BRIEF.md
# Page-Mapped Logical-to-Physical Translator

This block holds a page-granular translation table for a small flash array built from a few erase blocks, each with a few pages. Commands come in on a valid/ready channel and carry an operation code and a logical page number. Each accepted command produces one response on a second valid/ready channel. A host write never reprograms a page in place. It takes the next erased page of the currently open block and repoints the table entry to that page. The page that held the old copy becomes stale. A trim drops the mapping and marks the page stale without programming anything. A move operation lets a reclamation engine relocate still-live data the same way a write does, but it is not counted as host traffic.

The block keeps a valid bit for every physical page and a live-page count for every erase block, and presents both to the reclamation engine. That engine returns an empty block to the free pool by pulsing an erase request. Two running counters, one for host writes and one for page programs, give the write amplification. Back-pressure works as follows. The command channel is ready only while no response is waiting. A response, once valid, holds its value until `rsp_ready` is sampled high. The program strobe and the erase request are plain single-cycle pins.

Top module: `l2p_translator`

## Requirements
- R1: After reset every logical page is unmapped, the page valid map and all block counts are zero, both traffic counters are zero, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A write (op 2'b01) goes to the next page, in ascending order, of the open block. When no block is open, the lowest-numbered free block is opened at page 0. A block closes after its last page is used. The physical address is block*PAGES_PER_BLK + page, and the response carries it.
- R3: A program strobe only ever targets a page whose valid bit was clear the cycle before, and it sets that bit.
- R4: Writing a logical page that is already mapped clears the valid bit of its old physical page and points the entry at the new page.
- R5: A read (op 2'b00) of a mapped page returns its physical address with `rsp_unmapped`=0. A read of an unmapped page returns all ones with `rsp_unmapped`=1.
- R6: A trim (op 2'b10) of a mapped page returns the old address, clears its valid bit and unmaps the entry, with no program. A trim of an unmapped page returns all ones with `rsp_unmapped`=1 and changes nothing.
- R7: A write or move that needs a page when no block is open and none is free responds with `rsp_busy`=1 and `rsp_ppa` all ones. It issues no program and changes no state.
- R8: Each block's live count always equals the number of set valid bits in that block's slice of the valid map.
- R9: `host_wr_cnt` rises by one for each write that programs. `prog_cnt` rises by one for each program strobe, whether from a write or a move.
- R10: A move (op 2'b11) of a mapped page relocates it like a write but leaves `host_wr_cnt` unchanged. A move of an unmapped page returns all ones with `rsp_unmapped`=1 and changes nothing.
- R11: A pulse on `erase_valid` frees block `erase_blk` only when that block is not free, not open and has a live count of zero. Otherwise the pulse is ignored.
- R12: A command is accepted only when `cmd_ready` is high, and `cmd_ready` is low while a response is pending. The response appears the cycle after acceptance and holds stable until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 00 read, 01 write, 10 trim, 11 move |
| cmd_lpn | input | LPN_W | Logical page number |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_ppa | output | PPA_W | Physical address, or all ones |
| rsp_unmapped | output | 1 | Logical page had no mapping |
| rsp_busy | output | 1 | Command refused, no erased page |
| prog_valid | output | 1 | One-cycle program strobe |
| prog_ppa | output | PPA_W | Page being programmed |
| erase_valid | input | 1 | Erase request pulse |
| erase_blk | input | BLK_W | Block to erase |
| valid_map | output | NUM_BLOCKS*PAGES_PER_BLK | Live bit per physical page |
| blk_valid_cnt | output | NUM_BLOCKS*VC_W | Live page count per block |
| host_wr_cnt | output | CNT_W | Host writes that programmed |
| prog_cnt | output | CNT_W | Page programs issued |

## Verification
The bench builds the block with three blocks of four pages and six logical pages. With twelve physical pages and only six names, a few dozen commands are enough to fill blocks, cross block boundaries, exhaust the free pool and hit the busy refusal. They also cover erase refusals for a live block and for the open block, and the reuse of an erased block at page 0. A response throttle that is low one cycle in three keeps responses waiting, which exercises the hold rule and the stalled command channel.

// File: rtl/l2p_pkg.sv
package l2p_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_TRIM  = 2'b10,
    OP_MOVE  = 2'b11
  } l2p_op_e;

  function automatic int unsigned wbits(int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/l2p_map_table.sv
module l2p_map_table #(
  parameter int NUM_LPN = 8,
  parameter int PPA_W   = 4,
  localparam int LPN_W  = l2p_pkg::wbits(NUM_LPN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LPN_W-1:0] rd_lpn,
  output logic [PPA_W-1:0] rd_ppa,
  output logic             rd_mapped,
  input  logic             wr_en,
  input  logic [LPN_W-1:0] wr_lpn,
  input  logic             wr_mapped,
  input  logic [PPA_W-1:0] wr_ppa
);
  logic [PPA_W-1:0]   ppa_q [NUM_LPN];
  logic [NUM_LPN-1:0] mapped_q;

  always_comb begin
    rd_ppa    = '0;
    rd_mapped = 1'b0;
    for (int i = 0; i < NUM_LPN; i++) begin
      if (rd_lpn == LPN_W'(i)) begin
        rd_ppa    = ppa_q[i];
        rd_mapped = mapped_q[i];
      end
    end
  end

  for (genvar i = 0; i < NUM_LPN; i++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_lpn == LPN_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mapped_q[i] <= 1'b0;
        ppa_q[i]    <= '0;
      end else if (hit) begin
        mapped_q[i] <= wr_mapped;
        ppa_q[i]    <= wr_ppa;
      end
    end
  end
endmodule

// File: rtl/l2p_page_state.sv
module l2p_page_state #(
  parameter int NUM_BLOCKS    = 4,
  parameter int PAGES_PER_BLK = 4,
  localparam int TOTAL = NUM_BLOCKS * PAGES_PER_BLK,
  localparam int PPA_W = l2p_pkg::wbits(TOTAL),
  localparam int BLK_W = l2p_pkg::wbits(NUM_BLOCKS),
  localparam int VC_W  = $clog2(PAGES_PER_BLK + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [PPA_W-1:0]           set_ppa,
  input  logic                       clr_en,
  input  logic [PPA_W-1:0]           clr_ppa,
  output logic [TOTAL-1:0]           valid_map,
  output logic [NUM_BLOCKS*VC_W-1:0] blk_cnt
);
  logic [BLK_W-1:0] set_blk, clr_blk;
  assign set_blk = BLK_W'(set_ppa / PPA_W'(PAGES_PER_BLK));
  assign clr_blk = BLK_W'(clr_ppa / PPA_W'(PAGES_PER_BLK));

  for (genvar p = 0; p < TOTAL; p++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rst_n) valid_map[p] <= 1'b0;
      else if (set_en && set_ppa == PPA_W'(p)) valid_map[p] <= 1'b1;
      else if (clr_en && clr_ppa == PPA_W'(p)) valid_map[p] <= 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic            inc, dec;
    logic [VC_W-1:0] cnt_q;
    assign inc = set_en && (set_blk == BLK_W'(b));
    assign dec = clr_en && (clr_blk == BLK_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + VC_W'(inc) - VC_W'(dec);
    end
    assign blk_cnt[b*VC_W +: VC_W] = cnt_q;
  end
endmodule

// File: rtl/l2p_alloc.sv
module l2p_alloc #(
  parameter int NUM_BLOCKS    = 4,
  parameter int PAGES_PER_BLK = 4,
  localparam int TOTAL = NUM_BLOCKS * PAGES_PER_BLK,
  localparam int PPA_W = l2p_pkg::wbits(TOTAL),
  localparam int BLK_W = l2p_pkg::wbits(NUM_BLOCKS),
  localparam int IDX_W = l2p_pkg::wbits(PAGES_PER_BLK),
  localparam int VC_W  = $clog2(PAGES_PER_BLK + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic                       erase_valid,
  input  logic [BLK_W-1:0]           erase_blk,
  input  logic [NUM_BLOCKS*VC_W-1:0] blk_cnt,
  output logic                       avail,
  output logic [PPA_W-1:0]           next_ppa
);
  logic [NUM_BLOCKS-1:0] free_q;
  logic                  open_q;
  logic [BLK_W-1:0]      oblk_q;
  logic [IDX_W-1:0]      ptr_q;

  logic [BLK_W-1:0]      first_free;
  logic                  any_free;
  logic [BLK_W-1:0]      cur_blk;
  logic [IDX_W-1:0]      cur_idx;
  logic                  last_page;
  logic [NUM_BLOCKS-1:0] take_mask, erase_hit;

  always_comb begin
    first_free = '0;
    any_free   = 1'b0;
    for (int b = NUM_BLOCKS - 1; b >= 0; b--) begin
      if (free_q[b]) begin
        first_free = BLK_W'(b);
        any_free   = 1'b1;
      end
    end
  end

  assign cur_blk   = open_q ? oblk_q : first_free;
  assign cur_idx   = open_q ? ptr_q : '0;
  assign avail     = open_q || any_free;
  assign next_ppa  = PPA_W'(cur_blk) * PPA_W'(PAGES_PER_BLK) + PPA_W'(cur_idx);
  assign last_page = (cur_idx == IDX_W'(PAGES_PER_BLK - 1));
  assign take_mask = (take && !open_q) ? (NUM_BLOCKS'(1) << first_free) : '0;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_erase
    assign erase_hit[b] = erase_valid && (erase_blk == BLK_W'(b)) && !free_q[b]
                        && !(open_q && oblk_q == BLK_W'(b))
                        && (blk_cnt[b*VC_W +: VC_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= {NUM_BLOCKS{1'b1}};
      open_q <= 1'b0;
      oblk_q <= '0;
      ptr_q  <= '0;
    end else begin
      free_q <= (free_q & ~take_mask) | erase_hit;
      if (take) begin
        if (last_page) begin
          open_q <= 1'b0;
        end else begin
          open_q <= 1'b1;
          oblk_q <= cur_blk;
          ptr_q  <= cur_idx + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/l2p_translator.sv
module l2p_translator #(
  parameter int NUM_BLOCKS    = 4,
  parameter int PAGES_PER_BLK = 4,
  parameter int NUM_LPN       = 8,
  parameter int CNT_W         = 16,
  localparam int TOTAL = NUM_BLOCKS * PAGES_PER_BLK,
  localparam int PPA_W = l2p_pkg::wbits(TOTAL),
  localparam int BLK_W = l2p_pkg::wbits(NUM_BLOCKS),
  localparam int LPN_W = l2p_pkg::wbits(NUM_LPN),
  localparam int VC_W  = $clog2(PAGES_PER_BLK + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic [LPN_W-1:0]           cmd_lpn,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [PPA_W-1:0]           rsp_ppa,
  output logic                       rsp_unmapped,
  output logic                       rsp_busy,
  output logic                       prog_valid,
  output logic [PPA_W-1:0]           prog_ppa,
  input  logic                       erase_valid,
  input  logic [BLK_W-1:0]           erase_blk,
  output logic [TOTAL-1:0]           valid_map,
  output logic [NUM_BLOCKS*VC_W-1:0] blk_valid_cnt,
  output logic [CNT_W-1:0]           host_wr_cnt,
  output logic [CNT_W-1:0]           prog_cnt
);
  import l2p_pkg::*;

  l2p_op_e          op;
  logic             accept, is_wr, is_mv, is_tr;
  logic             needs_page, do_prog, refuse, do_inval, map_wr;
  logic [PPA_W-1:0] cur_ppa, new_ppa;
  logic             cur_mapped, avail;

  assign op         = l2p_op_e'(cmd_op);
  assign cmd_ready  = !rsp_valid;
  assign accept     = cmd_valid && cmd_ready;
  assign is_wr      = (op == OP_WRITE);
  assign is_mv      = (op == OP_MOVE);
  assign is_tr      = (op == OP_TRIM);
  assign needs_page = accept && (is_wr || (is_mv && cur_mapped));
  assign do_prog    = needs_page && avail;
  assign refuse     = needs_page && !avail;
  assign do_inval   = cur_mapped && (do_prog || (accept && is_tr));
  assign map_wr     = do_prog || (accept && is_tr && cur_mapped);

  l2p_map_table #(.NUM_LPN(NUM_LPN), .PPA_W(PPA_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_lpn   (cmd_lpn),
    .rd_ppa   (cur_ppa),
    .rd_mapped(cur_mapped),
    .wr_en    (map_wr),
    .wr_lpn   (cmd_lpn),
    .wr_mapped(do_prog),
    .wr_ppa   (new_ppa)
  );

  l2p_page_state #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLK(PAGES_PER_BLK)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (do_prog),
    .set_ppa  (new_ppa),
    .clr_en   (do_inval),
    .clr_ppa  (cur_ppa),
    .valid_map(valid_map),
    .blk_cnt  (blk_valid_cnt)
  );

  l2p_alloc #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLK(PAGES_PER_BLK)) u_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (do_prog),
    .erase_valid(erase_valid),
    .erase_blk  (erase_blk),
    .blk_cnt    (blk_valid_cnt),
    .avail      (avail),
    .next_ppa   (new_ppa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_ppa      <= '1;
      rsp_unmapped <= 1'b0;
      rsp_busy     <= 1'b0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_busy     <= refuse;
      rsp_unmapped <= !cur_mapped && !is_wr;
      if (do_prog)                   rsp_ppa <= new_ppa;
      else if (!refuse && cur_mapped) rsp_ppa <= cur_ppa;
      else                           rsp_ppa <= '1;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_valid  <= 1'b0;
      prog_ppa    <= '0;
      host_wr_cnt <= '0;
      prog_cnt    <= '0;
    end else begin
      prog_valid <= do_prog;
      if (do_prog) begin
        prog_ppa <= new_ppa;
        prog_cnt <= prog_cnt + CNT_W'(1);
        if (is_wr) host_wr_cnt <= host_wr_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/l2p_translator_chk.sv
module l2p_translator_chk #(
  parameter int NUM_BLOCKS    = 4,
  parameter int PAGES_PER_BLK = 4,
  parameter int CNT_W         = 16,
  localparam int TOTAL = NUM_BLOCKS * PAGES_PER_BLK,
  localparam int PPA_W = l2p_pkg::wbits(TOTAL),
  localparam int VC_W  = $clog2(PAGES_PER_BLK + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [PPA_W-1:0]           rsp_ppa,
  input logic                       rsp_unmapped,
  input logic                       rsp_busy,
  input logic                       prog_valid,
  input logic [PPA_W-1:0]           prog_ppa,
  input logic [TOTAL-1:0]           valid_map,
  input logic [NUM_BLOCKS*VC_W-1:0] blk_valid_cnt,
  input logic [CNT_W-1:0]           host_wr_cnt,
  input logic [CNT_W-1:0]           prog_cnt
);
  logic [TOTAL-1:0] prev_map;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_map <= '0;
    else        prev_map <= valid_map;
  end

  AST_PROG_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> (!prev_map[prog_ppa] && valid_map[prog_ppa])); // R3

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cnt
    AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid_cnt[b*VC_W +: VC_W] == VC_W'($countones(valid_map[b*PAGES_PER_BLK +: PAGES_PER_BLK]))); // R8
  end

  AST_UNMAP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unmapped) |-> (rsp_ppa == '1)); // R5

  AST_BUSY_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_busy) |-> (!prog_valid && valid_map == prev_map)); // R7

  AST_PROG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> (prog_cnt == $past(prog_cnt) + CNT_W'(1))); // R9

  AST_HOST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_cnt <= prog_cnt); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ppa) && $stable(rsp_busy) && $stable(rsp_unmapped))); // R12

  AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(cmd_valid && cmd_ready)); // R12
endmodule

bind l2p_translator l2p_translator_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLK(PAGES_PER_BLK), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ppa(rsp_ppa),
  .rsp_unmapped(rsp_unmapped), .rsp_busy(rsp_busy), .prog_valid(prog_valid),
  .prog_ppa(prog_ppa), .valid_map(valid_map), .blk_valid_cnt(blk_valid_cnt),
  .host_wr_cnt(host_wr_cnt), .prog_cnt(prog_cnt)
);

// File: tb/l2p_translator_tb_top.sv
module l2p_translator_tb_top;
  import l2p_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 3;
  localparam int PPB   = 4;
  localparam int NLPN  = 6;
  localparam int CNT_W = 16;
  localparam int TOTAL = NB * PPB;
  localparam int PPA_W = 4;
  localparam int BLK_W = 2;
  localparam int LPN_W = 3;
  localparam int VC_W  = 3;
  localparam int ONES  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [LPN_W-1:0] cmd_lpn = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [PPA_W-1:0] rsp_ppa;
  logic rsp_unmapped, rsp_busy, prog_valid;
  logic [PPA_W-1:0] prog_ppa;
  logic erase_valid = 1'b0;
  logic [BLK_W-1:0] erase_blk = '0;
  logic [TOTAL-1:0] valid_map;
  logic [NB*VC_W-1:0] blk_valid_cnt;
  logic [CNT_W-1:0] host_wr_cnt, prog_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2p_translator #(.NUM_BLOCKS(NB), .PAGES_PER_BLK(PPB), .NUM_LPN(NLPN), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_lpn(cmd_lpn), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_ppa(rsp_ppa), .rsp_unmapped(rsp_unmapped), .rsp_busy(rsp_busy),
    .prog_valid(prog_valid), .prog_ppa(prog_ppa), .erase_valid(erase_valid),
    .erase_blk(erase_blk), .valid_map(valid_map), .blk_valid_cnt(blk_valid_cnt),
    .host_wr_cnt(host_wr_cnt), .prog_cnt(prog_cnt)
  );

  typedef struct {
    int    ppa;
    bit    unm;
    bit    busy;
    string req;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model built from the requirements
  int m_map[NLPN];
  bit m_valid[TOTAL];
  bit m_free[NB];
  bit m_open;
  int m_oblk, m_ptr, m_host, m_prog;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mdl_count(int b);
    int c = 0;
    for (int p = 0; p < PPB; p++) c += int'(m_valid[b*PPB + p]);
    return c;
  endfunction

  task automatic check_state(string req);
    logic [TOTAL-1:0] ev;
    for (int p = 0; p < TOTAL; p++) ev[p] = m_valid[p];
    check({req, " valid map"}, int'(valid_map), int'(ev));
    for (int b = 0; b < NB; b++)
      check("R8 block count", int'(blk_valid_cnt[b*VC_W +: VC_W]), mdl_count(b));
    check("R9 host count", int'(host_wr_cnt), m_host);
    check("R9 program count", int'(prog_cnt), m_prog);
  endtask

  // driver: computes the expected response, pushes it, then issues the command
  task automatic send(l2p_op_e op, int lpn, string req);
    exp_t e;
    int   prog = -1;
    bit   mapped = (m_map[lpn] >= 0);
    bit   needs = (op == OP_WRITE) || (op == OP_MOVE && mapped);
    e.req = req; e.unm = 1'b0; e.busy = 1'b0; e.ppa = ONES;
    if (needs) begin
      int fb = -1;
      for (int b = NB - 1; b >= 0; b--) if (m_free[b]) fb = b;
      if (m_open || fb >= 0) begin
        int blk = m_open ? m_oblk : fb;
        int idx = m_open ? m_ptr : 0;
        prog = blk * PPB + idx;
        if (!m_open) m_free[fb] = 1'b0;
        if (idx == PPB - 1) m_open = 1'b0;
        else begin m_open = 1'b1; m_oblk = blk; m_ptr = idx + 1; end
        if (mapped) m_valid[m_map[lpn]] = 1'b0;
        m_valid[prog] = 1'b1;
        m_map[lpn] = prog;
        m_prog++;
        if (op == OP_WRITE) m_host++;
        e.ppa = prog;
      end else begin
        e.busy = 1'b1;
      end
    end else begin
      e.unm = !mapped;
      e.ppa = mapped ? m_map[lpn] : ONES;
      if (op == OP_TRIM && mapped) begin
        m_valid[m_map[lpn]] = 1'b0;
        m_map[lpn] = -1;
      end
    end
    q.push_back(e);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_lpn   = LPN_W'(lpn);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " program strobe"}, int'(prog_valid), int'(prog >= 0));
    if (prog >= 0) check({req, " program address (R3)"}, int'(prog_ppa), prog);
    if (rsp_valid) check("R12 ready low while pending", int'(cmd_ready), 0);
    check_state(req);
  endtask

  task automatic erase(int b, string req);
    bit ok = !m_free[b] && !(m_open && m_oblk == b) && (mdl_count(b) == 0);
    if (ok) m_free[b] = 1'b1;
    erase_valid = 1'b1;
    erase_blk   = BLK_W'(b);
    @(negedge clk);
    erase_valid = 1'b0;
    check_state(req);
  endtask

  // monitor: throttles the response channel, pops and compares at handshake
  int cyc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      cyc++;
      rsp_ready = (cyc % 3) != 0;
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R12: unexpected response actual 1 expected 0");
        end else begin
          e = q.pop_front();
          check({e.req, " rsp_ppa"}, int'(rsp_ppa), e.ppa);
          check({e.req, " rsp_unmapped"}, int'(rsp_unmapped), int'(e.unm));
          check({e.req, " rsp_busy"}, int'(rsp_busy), int'(e.busy));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R12: watchdog expired actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NLPN; i++) m_map[i] = -1;
    for (int p = 0; p < TOTAL; p++) m_valid[p] = 1'b0;
    for (int b = 0; b < NB; b++) m_free[b] = 1'b1;
    m_open = 1'b0; m_oblk = 0; m_ptr = 0; m_host = 0; m_prog = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cmd_ready", int'(cmd_ready), 1);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 prog_valid", int'(prog_valid), 0);
    check_state("R1");

    send(OP_READ, 0, "R5 unmapped read");
    for (int i = 0; i < NLPN; i++) send(OP_WRITE, i, "R2 ordered write");
    send(OP_WRITE, 0, "R4 overwrite");
    send(OP_READ, 0, "R5 mapped read");
    send(OP_TRIM, 1, "R6 trim mapped");
    send(OP_READ, 1, "R6 read after trim");
    send(OP_TRIM, 1, "R6 trim unmapped");
    send(OP_MOVE, 2, "R10 move mapped");
    send(OP_MOVE, 1, "R10 move unmapped");
    erase(0, "R11 erase with live page");
    send(OP_WRITE, 3, "R2 new block");
    erase(2, "R11 erase open block");
    erase(0, "R11 erase empty block");
    send(OP_WRITE, 4, "R11 open block continues");
    send(OP_WRITE, 5, "R2 write");
    send(OP_WRITE, 0, "R2 fill block");
    send(OP_WRITE, 4, "R11 reuse erased block");
    send(OP_WRITE, 5, "R4 overwrite");
    send(OP_WRITE, 0, "R4 overwrite");
    send(OP_WRITE, 4, "R2 fill reused block");
    send(OP_WRITE, 3, "R7 pool empty write");
    send(OP_MOVE, 3, "R7 pool empty move");
    send(OP_READ, 3, "R7 state unchanged");
    erase(1, "R11 erase with live page");
    send(OP_TRIM, 2, "R6 trim last live");
    erase(1, "R11 erase after trim");
    send(OP_WRITE, 3, "R2 write to freed block");
    send(OP_READ, 3, "R5 read back");

    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    check("R12 idle ready", int'(cmd_ready), 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule